// File: doc/BRIEF.md
# Trap Target Address Generator

This block works out where a hart resumes after it takes a trap. When the trap-entry logic pulses `start`, the block looks at the trap-vector register value, the vector-table base register value, whether the trap is asynchronous, the cause or interrupt number, and whether that interrupt wants hardware vectoring. Most trap targets are plain arithmetic on these values, and the block reports them one cycle later.

The two low bits of the trap-vector value choose one of four behaviours:

- **Direct:** jump to the aligned base.
- **Vectored:** jump to the base plus four times the cause.
- **Reserved:** handled like direct.
- **Interrupt-controller mode:** depends on hardware vectoring, described below.

In interrupt-controller mode, an interrupt without hardware vectoring goes to a 64-byte aligned common entry. A hardware-vectored interrupt indexes a table at the aligned vector-table base. In jump-table operation the block jumps straight to the table slot. In pointer-table operation it fetches the slot through a small read port, and the fetched word, with bit 0 cleared, becomes the target. A read error is reported as an access fault instead of a target address.

Top module: `trap_target_gen`

## Requirements
- R1: After reset, `done`, `memReq` and `fault` are 0 and `pcOut` is 0.
- R2: When `isAsync` is 0, the target is `tvecVal` with bits [1:0] cleared, whatever the mode. `done` pulses in the cycle after `start` is sampled, and no memory request is made.
- R3: For an asynchronous trap with `tvecVal[1:0]` equal to 0 (direct) or 2 (reserved), the target is `tvecVal` with bits [1:0] cleared, due one cycle after `start`.
- R4: For an asynchronous trap with `tvecVal[1:0]` equal to 1 (vectored), the target is (`tvecVal` with bits [1:0] cleared) + 4 × `causeId`.
- R5: With `tvecVal[1:0]` equal to 3 (interrupt-controller mode), an asynchronous trap with `shvAttr` at 0 or `hwVecEn` at 0 goes to `tvecVal` with bits [5:0] cleared.
- R6: In interrupt-controller mode with `shvAttr` and `hwVecEn` both 1 and `jumpTable` at 1, the target is (`tvtVal` with bits [5:0] cleared) + (XLEN/8) × `causeId`. It is due one cycle after `start`, and no memory request is made.
- R7: In the same case with `jumpTable` at 0, `memReq` rises in the cycle after `start`. While it is high, `memAddr` holds that same entry address and `memSize` equals XLEN/8. Both stay stable until a cycle in which `memReqReady` is 1.
- R8: After the request is accepted, `done` pulses one cycle after the edge that samples `rspValid`. `pcOut` is then `rspData` with bit 0 cleared and `fault` is 0.
- R9: If `rspErr` is 1 with `rspValid`, `done` pulses with `fault` at 1 and `pcOut` at 0.
- R10: `done` lasts exactly one cycle, and `start` is ignored while an operation is in progress.
- R11: `fault` returns to 0 with the next result that is not a failed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin computing a trap target |
| isAsync | input | 1 | 1 for an interrupt, 0 for a synchronous exception |
| tvecVal | input | XLEN | Trap-vector register value; bits [1:0] select the mode |
| tvtVal | input | XLEN | Vector-table base register value |
| causeId | input | CAUSE_W | Cause code or interrupt number |
| shvAttr | input | 1 | Interrupt requests hardware vectoring |
| hwVecEn | input | 1 | Hardware vectoring enabled by configuration |
| jumpTable | input | 1 | 1: table slots are jump targets; 0: slots hold pointers |
| memReq | output | 1 | Table read request |
| memReqReady | input | 1 | Read request accepted |
| memAddr | output | XLEN | Table read address |
| memSize | output | 4 | Read size in bytes (XLEN/8) |
| rspValid | input | 1 | Read response valid |
| rspErr | input | 1 | Read response is an access error |
| rspData | input | XLEN | Read response data |
| done | output | 1 | One-cycle result strobe |
| pcOut | output | XLEN | Computed trap target |
| fault | output | 1 | Table read failed |

## Verification
Every target that needs no memory read is due in the cycle right after the edge that samples `start`. The bench raises `start` at a falling edge and checks `done` and `pcOut` at the next falling edge. It then checks one falling edge later that `done` has dropped. For a pointer fetch, the request is checked at that same first falling edge. It is checked again while `memReqReady` is held low. The result is checked at the falling edge after the one where `rspValid` was raised. This keeps every sample half a period away from the edge that moves the state.

// File: rtl/trap_target_pkg.sv
package trap_target_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ_REQ,
    ST_READ_WAIT,
    ST_DONE
  } trapState_t;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_VECTORED = 2'd1,
    MODE_RESERVED = 2'd2,
    MODE_CTRL     = 2'd3
  } vecMode_t;

  typedef struct packed {
    logic captureAddr;
    logic loadImm;
    logic loadRsp;
    logic loadFault;
  } ctrlStrobes_t;

endpackage

// File: rtl/trap_target_dp.sv
module trap_target_dp
  import trap_target_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       stb,
  input  logic               isAsync,
  input  logic [XLEN-1:0]    tvecVal,
  input  logic [XLEN-1:0]    tvtVal,
  input  logic [CAUSE_W-1:0] causeId,
  input  logic               shvAttr,
  input  logic               hwVecEn,
  input  logic               jumpTable,
  input  logic [XLEN-1:0]    rspData,
  output logic               needFetch,
  output logic [XLEN-1:0]    memAddr,
  output logic [XLEN-1:0]    pcOut,
  output logic               fault
);
  localparam int SLOT_SHIFT = (XLEN == 64) ? 3 : 2;

  logic [XLEN-1:0] causeExt;
  logic [XLEN-1:0] oBase;
  logic [XLEN-1:0] nBase;
  logic [XLEN-1:0] tBase;
  logic [XLEN-1:0] entryAddr;
  logic [XLEN-1:0] immTarget;
  logic            hwVec;
  vecMode_t        mode;

  assign causeExt  = XLEN'(causeId);
  assign oBase     = {tvecVal[XLEN-1:2], 2'b00};
  assign nBase     = {tvecVal[XLEN-1:6], 6'b000000};
  assign tBase     = {tvtVal[XLEN-1:6], 6'b000000};
  assign entryAddr = tBase + (causeExt << SLOT_SHIFT);
  assign mode      = vecMode_t'(tvecVal[1:0]);
  assign hwVec     = shvAttr && hwVecEn;
  assign needFetch = isAsync && (mode == MODE_CTRL) && hwVec && !jumpTable;

  always_comb begin
    immTarget = oBase;
    if (isAsync) begin
      unique case (mode)
        MODE_VECTORED: immTarget = oBase + (causeExt << 2);
        MODE_CTRL:     immTarget = hwVec ? entryAddr : nBase;
        default:       immTarget = oBase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memAddr <= '0;
      pcOut   <= '0;
      fault   <= 1'b0;
    end else begin
      if (stb.captureAddr) memAddr <= entryAddr;
      if (stb.loadImm) begin
        pcOut <= immTarget;
        fault <= 1'b0;
      end else if (stb.loadRsp) begin
        pcOut <= {rspData[XLEN-1:1], 1'b0};
        fault <= 1'b0;
      end else if (stb.loadFault) begin
        pcOut <= '0;
        fault <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trap_target_ctrl.sv
module trap_target_ctrl
  import trap_target_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         needFetch,
  input  logic         memReqReady,
  input  logic         rspValid,
  input  logic         rspErr,
  output ctrlStrobes_t stb,
  output logic         memReq,
  output logic         done
);
  trapState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    memReq    = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (needFetch) begin
            stb.captureAddr = 1'b1;
            nextState       = ST_READ_REQ;
          end else begin
            stb.loadImm = 1'b1;
            nextState   = ST_DONE;
          end
        end
      end
      ST_READ_REQ: begin
        memReq = 1'b1;
        if (memReqReady) nextState = ST_READ_WAIT;
      end
      ST_READ_WAIT: begin
        if (rspValid) begin
          if (rspErr) stb.loadFault = 1'b1;
          else        stb.loadRsp   = 1'b1;
          nextState = ST_DONE;
        end
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/trap_target_gen.sv
module trap_target_gen
  import trap_target_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               isAsync,
  input  logic [XLEN-1:0]    tvecVal,
  input  logic [XLEN-1:0]    tvtVal,
  input  logic [CAUSE_W-1:0] causeId,
  input  logic               shvAttr,
  input  logic               hwVecEn,
  input  logic               jumpTable,
  output logic               memReq,
  input  logic               memReqReady,
  output logic [XLEN-1:0]    memAddr,
  output logic [3:0]         memSize,
  input  logic               rspValid,
  input  logic               rspErr,
  input  logic [XLEN-1:0]    rspData,
  output logic               done,
  output logic [XLEN-1:0]    pcOut,
  output logic               fault
);
  localparam int SLOT_BYTES = XLEN / 8;

  ctrlStrobes_t stb;
  logic         needFetch;

  assign memSize = 4'(SLOT_BYTES);

  trap_target_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .needFetch  (needFetch),
    .memReqReady(memReqReady),
    .rspValid   (rspValid),
    .rspErr     (rspErr),
    .stb        (stb),
    .memReq     (memReq),
    .done       (done)
  );

  trap_target_dp #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .isAsync  (isAsync),
    .tvecVal  (tvecVal),
    .tvtVal   (tvtVal),
    .causeId  (causeId),
    .shvAttr  (shvAttr),
    .hwVecEn  (hwVecEn),
    .jumpTable(jumpTable),
    .rspData  (rspData),
    .needFetch(needFetch),
    .memAddr  (memAddr),
    .pcOut    (pcOut),
    .fault    (fault)
  );
endmodule

// File: rtl/trap_target_chk.sv
module trap_target_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done,
  input logic            memReq,
  input logic            memReqReady,
  input logic [XLEN-1:0] memAddr,
  input logic [XLEN-1:0] pcOut,
  input logic            fault
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memReqReady) |=> (memReq && $stable(memAddr)));

  // R7
  req_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> !done);

  // R9
  fault_pc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (pcOut == '0));

  // R8
  pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pcOut[0]);
endmodule

bind trap_target_gen trap_target_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .memReq     (memReq),
  .memReqReady(memReqReady),
  .memAddr    (memAddr),
  .pcOut      (pcOut),
  .fault      (fault)
);

// File: tb/tb_trap_target_gen.sv
module tb_trap_target_gen;
  localparam int XLEN    = 32;
  localparam int CAUSE_W = 12;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic               isAsync = 1'b0;
  logic [XLEN-1:0]    tvecVal = '0;
  logic [XLEN-1:0]    tvtVal = '0;
  logic [CAUSE_W-1:0] causeId = '0;
  logic               shvAttr = 1'b0;
  logic               hwVecEn = 1'b0;
  logic               jumpTable = 1'b0;
  logic               memReq;
  logic               memReqReady = 1'b0;
  logic [XLEN-1:0]    memAddr;
  logic [3:0]         memSize;
  logic               rspValid = 1'b0;
  logic               rspErr = 1'b0;
  logic [XLEN-1:0]    rspData = '0;
  logic               done;
  logic [XLEN-1:0]    pcOut;
  logic               fault;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  trap_target_gen #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .isAsync(isAsync),
    .tvecVal(tvecVal), .tvtVal(tvtVal), .causeId(causeId),
    .shvAttr(shvAttr), .hwVecEn(hwVecEn), .jumpTable(jumpTable),
    .memReq(memReq), .memReqReady(memReqReady), .memAddr(memAddr),
    .memSize(memSize), .rspValid(rspValid), .rspErr(rspErr),
    .rspData(rspData), .done(done), .pcOut(pcOut), .fault(fault)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Launch one operation; returns at the falling edge after start is sampled.
  task automatic launch(logic async, logic [XLEN-1:0] tv, logic [XLEN-1:0] tt,
                        logic [CAUSE_W-1:0] c, logic shv, logic hwv, logic jt);
    @(negedge clk);
    isAsync = async; tvecVal = tv; tvtVal = tt; causeId = c;
    shvAttr = shv; hwVecEn = hwv; jumpTable = jt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expectImmediate(string req, logic [XLEN-1:0] exp);
    check(req, "done", 64'(done), 64'd1);
    check(req, "pcOut", 64'(pcOut), 64'(exp));
    check(req, "fault", 64'(fault), 64'd0);
    check(req, "memReq", 64'(memReq), 64'd0);
    @(negedge clk);
    check("R10", "done drop", 64'(done), 64'd0);
  endtask

  task automatic testReset();
    check("R1", "done", 64'(done), 64'd0);
    check("R1", "memReq", 64'(memReq), 64'd0);
    check("R1", "fault", 64'(fault), 64'd0);
    check("R1", "pcOut", 64'(pcOut), 64'd0);
  endtask

  task automatic testSync();
    // R2: mode bits 3, but synchronous -> clear [1:0] only
    launch(1'b0, 32'h8000_1007, 32'h2000_0000, 12'd5, 1'b1, 1'b1, 1'b0);
    expectImmediate("R2", 32'h8000_1004);
  endtask

  task automatic testDirect();
    launch(1'b1, 32'h8000_0100, '0, 12'd7, 1'b0, 1'b0, 1'b0);
    expectImmediate("R3", 32'h8000_0100);
    launch(1'b1, 32'h8000_0102, '0, 12'd7, 1'b0, 1'b0, 1'b0);
    expectImmediate("R3", 32'h8000_0100);
  endtask

  task automatic testVectored();
    launch(1'b1, 32'h8000_0201, '0, 12'd11, 1'b0, 1'b0, 1'b0);
    expectImmediate("R4", 32'h8000_022C);
    launch(1'b1, 32'h8000_0201, '0, 12'd0, 1'b0, 1'b0, 1'b0);
    expectImmediate("R4", 32'h8000_0200);
  endtask

  task automatic testCtrlCommon();
    launch(1'b1, 32'h8000_0A7F, 32'h2000_0123, 12'd9, 1'b0, 1'b1, 1'b0);
    expectImmediate("R5", 32'h8000_0A40);
    launch(1'b1, 32'h8000_0A7F, 32'h2000_0123, 12'd9, 1'b1, 1'b0, 1'b0);
    expectImmediate("R5", 32'h8000_0A40);
  endtask

  task automatic testJumpTable();
    launch(1'b1, 32'h8000_0A7F, 32'h2000_0123, 12'd19, 1'b1, 1'b1, 1'b1);
    expectImmediate("R6", 32'h2000_014C);
  endtask

  task automatic testFetch(logic err, logic [XLEN-1:0] data);
    launch(1'b1, 32'h8000_0A7F, 32'h2000_0123, 12'd5, 1'b1, 1'b1, 1'b0);
    check("R7", "memReq", 64'(memReq), 64'd1);
    check("R7", "memAddr", 64'(memAddr), 64'h2000_0114);
    check("R7", "memSize", 64'(memSize), 64'd4);
    check("R7", "done", 64'(done), 64'd0);
    @(negedge clk);
    check("R7", "memReq held", 64'(memReq), 64'd1);
    check("R7", "memAddr held", 64'(memAddr), 64'h2000_0114);
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    check("R7", "memReq after accept", 64'(memReq), 64'd0);
    // R10: start while waiting must be ignored
    start = 1'b1; causeId = 12'd1; isAsync = 1'b0;
    @(negedge clk);
    check("R10", "busy start no done", 64'(done), 64'd0);
    start = 1'b0;
    rspValid = 1'b1; rspErr = err; rspData = data;
    @(negedge clk);
    rspValid = 1'b0; rspErr = 1'b0;
    check(err ? "R9" : "R8", "done", 64'(done), 64'd1);
    check(err ? "R9" : "R8", "fault", 64'(fault), 64'(err));
    check(err ? "R9" : "R8", "pcOut", 64'(pcOut), err ? 64'd0 : 64'({data[XLEN-1:1], 1'b0}));
    @(negedge clk);
    check("R10", "done drop", 64'(done), 64'd0);
    check("R10", "no relaunch", 64'(memReq), 64'd0);
    @(negedge clk);
    check("R10", "still idle", 64'(done), 64'd0);
  endtask

  task automatic testFaultClear();
    testFetch(1'b1, 32'hDEAD_BEEF);
    launch(1'b1, 32'h8000_0300, '0, 12'd3, 1'b0, 1'b0, 1'b0);
    check("R11", "fault cleared", 64'(fault), 64'd0);
    expectImmediate("R11", 32'h8000_0300);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testSync();
    testDirect();
    testVectored();
    testCtrlCommon();
    testJumpTable();
    testFetch(1'b0, 32'h1234_5677);
    testFaultClear();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule